// File: doc/BRIEF.md
# Thermal Shutdown Latch Controller

This block drives an active-low system shutdown output from temperature threshold results and keeps a record of which channels caused a shutdown. Five measured channels (one internal and four external) each supply a single over-critical indication. A per-channel link mask decides which of them may act on the shutdown output and on the record. A sixth channel, set in hardware, compares a temperature code against an externally supplied trip code. This channel acts on the shutdown output at all times and cannot be masked.

The shutdown output is registered. It asserts one clock after any active condition appears and releases by itself one clock after all conditions have gone. The cause record is an 8-bit status register at address 1Fh. Its flags stay set after the output releases. A read of that address clears only the flags whose condition is no longer present. The asynchronous reset input is synchronised inside the block before it releases the logic.

Top module: `tsd_latch_ctrl`

## Requirements
- R1: While reset is asserted, `shdn_n` is 1 and `tcrit_status` is 00h whatever the inputs are; the internal reset releases on the second rising clock edge after `rst_n` goes high.
- R2: A linked channel (its `link_en` bit is 1) whose `crit_hit` bit is 1 at a rising edge has its status flag set after that edge; flag positions are bit 0 internal, bit 1 external 1, bit 2 external 2, bit 3 external 3, bit 4 external 4.
- R3: A channel whose `link_en` bit is 0 never sets its status flag and never asserts `shdn_n`, whatever its `crit_hit` bit is.
- R4: `shdn_n` is 0 after every rising edge at which any linked channel is critical or `hw_temp >= hw_trip`, and is 1 after every edge at which none of these holds.
- R5: Status bit 7 is set when `hw_temp` is greater than or equal to `hw_trip`, with no mask; equality sets it, and `hw_temp = hw_trip - 1` does not.
- R6: Without a status read, a set flag stays set, including after `shdn_n` has released.
- R7: A read is `rd_en` = 1 with `rd_addr` = 1Fh at a rising edge. `tcrit_status` shows the pre-clear value during that cycle, and each flag whose condition is inactive at that edge is 0 after it.
- R8: A read leaves a flag set if its condition is active at the read edge, including a condition that first appears at that very edge.
- R9: `rd_en` = 1 with any `rd_addr` other than 1Fh has no effect on the status register.
- R10: Status bits 6 and 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| crit_hit | input | 5 | Over-critical indication per channel (bit 0 internal, bits 1 to 4 external 1 to 4) |
| link_en | input | 5 | Link mask tying each channel to the shutdown output and its flag |
| hw_temp | input | 8 | Temperature code of the hardware-set channel |
| hw_trip | input | 8 | Trip code set by external hardware |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| shdn_n | output | 1 | Active-low system shutdown, registered |
| tcrit_status | output | 8 | Shutdown cause register (bit 7 hardware channel, bits 4:0 channels) |

## Verification
Two actions can fall in the same edge: a read that clears flags and a channel event that sets a flag. The bench provokes this by issuing a read at 1Fh while one flag's condition persists, another flag's condition has lapsed, and a third channel turns critical in that same cycle. A reference model derived from the requirements predicts the register after each edge. The scoreboard judges the outcome: the persistent and new flags must survive the read, and the lapsed flag must clear.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned HW_BIT  = 7;
  localparam int unsigned MAX_CH  = HW_BIT;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/tsd_rst_sync.sv
module tsd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tsd_trip_cmp.sv
module tsd_trip_cmp #(
  parameter int unsigned TEMP_W = 8
) (
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] trip,
  output logic              at_or_above
);
  // unsigned compare; equality counts as a trip
  always_comb begin
    at_or_above = (temp >= trip);
  end
endmodule

// File: rtl/tsd_cause_latch.sv
module tsd_cause_latch
  import tsd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t events,
  input  logic  rd_hit,
  output stat_t status
);
  stat_t status_q;
  stat_t status_nxt;
  stat_t clr_mask;
  logic  upd_en;

  // a read drops only flags whose event is absent now; events always win
  always_comb begin
    clr_mask   = rd_hit ? ~events : '0;
    status_nxt = (status_q & ~clr_mask) | events;
    upd_en     = rd_hit | (|(events & ~status_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_q <= '0;
    else if (upd_en) status_q <= status_nxt;
  end

  assign status = status_q;
endmodule

// File: rtl/tsd_pin_drv.sv
module tsd_pin_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_any,
  output logic shdn_n
);
  logic shdn_n_q;
  logic shdn_n_nxt;

  always_comb begin
    shdn_n_nxt = ~trip_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shdn_n_q <= 1'b1;
    else        shdn_n_q <= shdn_n_nxt;
  end

  assign shdn_n = shdn_n_q;
endmodule

// File: rtl/tsd_latch_ctrl.sv
module tsd_latch_ctrl
  import tsd_pkg::*;
#(
  parameter int unsigned NUM_CH      = 5,
  parameter int unsigned TEMP_W      = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter logic [7:0]  STATUS_ADDR = 8'h1F,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] crit_hit,
  input  logic [NUM_CH-1:0] link_en,
  input  logic [TEMP_W-1:0] hw_temp,
  input  logic [TEMP_W-1:0] hw_trip,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              shdn_n,
  output logic [STAT_W-1:0] tcrit_status
);
  localparam int unsigned RSV_LO = NUM_CH;
  localparam int unsigned RSV_HI = HW_BIT - 1;

  logic  rst_core_n;
  logic  hw_hit;
  logic  rd_hit;
  stat_t events;
  stat_t status;

  tsd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  tsd_trip_cmp #(.TEMP_W(TEMP_W)) u_cmp (
    .temp        (hw_temp),
    .trip        (hw_trip),
    .at_or_above (hw_hit)
  );

  // event vector: masked channels low, reserved bits tied off, hw channel on top
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign events[g] = crit_hit[g] & link_en[g];
  end
  if (RSV_HI >= RSV_LO) begin : g_rsv
    assign events[RSV_HI:RSV_LO] = '0;
  end
  assign events[HW_BIT] = hw_hit;

  always_comb begin
    rd_hit = rd_en && (rd_addr == ADDR_W'(STATUS_ADDR));
  end

  tsd_cause_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .events (events),
    .rd_hit (rd_hit),
    .status (status)
  );

  tsd_pin_drv u_pin (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .trip_any (|events),
    .shdn_n   (shdn_n)
  );

  assign tcrit_status = status;
endmodule

// File: rtl/tsd_latch_ctrl_chk.sv
module tsd_latch_ctrl_chk #(
  parameter int unsigned NUM_CH      = 5,
  parameter int unsigned TEMP_W      = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter logic [7:0]  STATUS_ADDR = 8'h1F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] crit_hit,
  input logic [NUM_CH-1:0] link_en,
  input logic [TEMP_W-1:0] hw_temp,
  input logic [TEMP_W-1:0] hw_trip,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              shdn_n,
  input logic [7:0]        tcrit_status
);
  logic [7:0] ev;
  logic       rd_hit;

  always_comb begin
    ev = '0;
    ev[NUM_CH-1:0] = crit_hit & link_en;
    ev[7] = (hw_temp >= hw_trip);
    rd_hit = rd_en && (rd_addr == ADDR_W'(STATUS_ADDR));
  end

  // R2 R3 R5 R6 R9: without a read, flags only accumulate events
  a_r6_sticky_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> tcrit_status == ($past(tcrit_status) | $past(ev)));

  // R7 R8: a read leaves exactly the flags whose event is present
  a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> tcrit_status == $past(ev));

  a_r4_assert: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> !shdn_n);

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ev) |=> shdn_n);

  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    tcrit_status[6:5] == 2'b00);
endmodule

bind tsd_latch_ctrl tsd_latch_ctrl_chk #(
  .NUM_CH(NUM_CH), .TEMP_W(TEMP_W), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .crit_hit     (crit_hit),
  .link_en      (link_en),
  .hw_temp      (hw_temp),
  .hw_trip      (hw_trip),
  .rd_en        (rd_en),
  .rd_addr      (rd_addr),
  .shdn_n       (shdn_n),
  .tcrit_status (tcrit_status)
);

// File: tb/test_tsd_latch_ctrl.sv
`timescale 1ns/1ps
module test_tsd_latch_ctrl;
  logic       clk;
  logic       rst_n;
  logic [4:0] crit_hit;
  logic [4:0] link_en;
  logic [7:0] hw_temp;
  logic [7:0] hw_trip;
  logic       rd_en;
  logic [7:0] rd_addr;
  logic       shdn_n;
  logic [7:0] tcrit_status;

  typedef struct {
    logic [7:0] st;
    logic       sd;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  exp_t       cur;
  int         n_cmp;
  int         n_bad;
  logic [7:0] m_st;
  bit         done;

  tsd_latch_ctrl i_tsd_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .crit_hit(crit_hit), .link_en(link_en),
    .hw_temp(hw_temp), .hw_trip(hw_trip), .rd_en(rd_en), .rd_addr(rd_addr),
    .shdn_n(shdn_n), .tcrit_status(tcrit_status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic direct_check(input logic [7:0] st, input logic sd, input string tag);
    n_cmp++;
    if (tcrit_status !== st || shdn_n !== sd) begin
      n_bad++;
      $display("FAIL %s: status=%h shdn_n=%b expected status=%h shdn_n=%b",
               tag, tcrit_status, shdn_n, st, sd);
    end
  endtask

  // driver: one clock per call, model predicts the state after the next edge
  task automatic step(input logic [4:0] c, input logic [4:0] l,
                      input logic [7:0] t, input logic [7:0] tr,
                      input logic r, input logic [7:0] a, input string tag);
    logic [7:0] ev;
    exp_t e;
    @(negedge clk);
    crit_hit = c; link_en = l; hw_temp = t; hw_trip = tr; rd_en = r; rd_addr = a;
    ev = {(t >= tr), 2'b00, c & l};
    if (r && a == 8'h1F) m_st = ev;
    else                 m_st = m_st | ev;
    e.st = m_st; e.sd = ~|ev; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares shortly after each edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      direct_check(cur.st, cur.sd, cur.tag);
    end
  end

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: status=%h shdn_n=%b expected run to finish", tcrit_status, shdn_n);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; m_st = '0; done = 0;
    rst_n = 1'b0;
    crit_hit = 5'h1F; link_en = 5'h1F; hw_temp = 8'd200; hw_trip = 8'd100;
    rd_en = 1'b0; rd_addr = 8'h00;
    repeat (3) begin
      @(negedge clk);
      direct_check(8'h00, 1'b1, "R1 outputs held during reset");
    end
    crit_hit = '0; link_en = '0; hw_temp = 8'd0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(5'h00, 5'h00, 8'd0, 8'd100, 1'b0, 8'h00, "R1 idle after release");

    // R2 R6 R7: each channel sets its own bit, sticks, then clears on read
    for (int i = 0; i < 5; i++) begin
      step(5'(1 << i), 5'h1F, 8'd0, 8'd100, 1'b0, 8'h00, "R2 linked channel sets flag, R4 assert");
      step(5'h00, 5'h1F, 8'd0, 8'd100, 1'b0, 8'h00, "R6 flag sticky after release, R4 release");
      step(5'h00, 5'h1F, 8'd0, 8'd100, 1'b1, 8'h1F, "R7 read clears lapsed flag");
    end

    // R3: unlinked channel has no effect
    step(5'b00100, 5'b11011, 8'd0, 8'd100, 1'b0, 8'h00, "R3 unlinked channel ignored");
    step(5'b00100, 5'b11011, 8'd0, 8'd100, 1'b0, 8'h00, "R3 unlinked channel ignored");

    // R5: trip compare boundaries
    step(5'h00, 5'h00, 8'd99, 8'd100, 1'b0, 8'h00, "R5 temp below trip no flag");
    step(5'h00, 5'h00, 8'd100, 8'd100, 1'b0, 8'h00, "R5 temp equal trip sets bit7 unmasked");
    step(5'h00, 5'h00, 8'd255, 8'd100, 1'b0, 8'h00, "R5 temp above trip");
    step(5'h00, 5'h00, 8'd10, 8'd100, 1'b0, 8'h00, "R6 bit7 sticky after release");

    // R9: read at wrong address
    step(5'h00, 5'h00, 8'd10, 8'd100, 1'b1, 8'h1E, "R9 other address no clear");
    step(5'h00, 5'h00, 8'd10, 8'd100, 1'b1, 8'h9F, "R9 other address no clear");
    step(5'h00, 5'h00, 8'd10, 8'd100, 1'b1, 8'h1F, "R7 read clears bit7");

    // R8: read collides with persistent and new events
    step(5'b00011, 5'h1F, 8'd0, 8'd100, 1'b0, 8'h00, "R2 two flags set");
    step(5'b00001, 5'h1F, 8'd0, 8'd100, 1'b0, 8'h00, "R6 bit1 lapses, stays set");
    step(5'b01001, 5'h1F, 8'd0, 8'd100, 1'b1, 8'h1F, "R8 read keeps active and new, clears lapsed");
    step(5'h00, 5'h1F, 8'd0, 8'd100, 1'b0, 8'h00, "R8 flags remain after colliding read");
    step(5'h00, 5'h1F, 8'd0, 8'd100, 1'b1, 8'h1F, "R7 final clear");

    // R10 plus mixed pattern
    step(5'h1F, 5'h1F, 8'd150, 8'd100, 1'b0, 8'h00, "R10 all sources, reserved bits zero");
    step(5'h00, 5'h00, 8'd0, 8'd100, 1'b1, 8'h1F, "R10 read all clear");
    step(5'h00, 5'h00, 8'd0, 8'd100, 1'b0, 8'h00, "R4 idle released");

    @(negedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule